// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a byte-addressed nonvolatile memory that sits on a two-wire (I2C-compatible) bus as a slave. It oversamples the serial clock and data lines with a fast system clock and finds Start and Stop conditions. It shifts in a device-select byte and compares it against a fixed prefix and three strap inputs. It then runs the write and read sequences, pulling the data line low for acknowledges and for zero bits of read data.

Inside, a word-address pointer tracks the current location. Write transactions load the pointer from two address bytes and then hand each data byte, with its address, to a separate write buffer. A Stop after written data raises a commit pulse. While that buffer reports busy, the engine refuses its device address, so a host can poll for completion. Read transactions fetch bytes through a combinational read port addressed by the pointer. A read can start at the pointer's current value, or at a fresh address set by a write-mode address phase followed by a repeated Start. Reads continue for as long as the host acknowledges.

Top module: `eep_slave_engine`

## Requirements
- R1: A Start (SDA falling while SCL is high) at any point ends the current transaction, releases SDA and restarts device-select reception; a Stop (SDA rising while SCL is high) releases SDA and returns the engine to idle. SDA changes while SCL is high are never taken as data.
- R2: The device-select byte is bits 7..4 = 1010, bits 3..1 = strap_i[2:0], bit 0 = direction (1 read, 0 write). On a match SDA is pulled low in the ninth clock. On a mismatch SDA stays released for the rest of the transaction, including later bytes, until the next Start.
- R3: While busy_i is high, the device-select byte is not acknowledged, even when it matches.
- R4: A write-mode transaction takes two word-address bytes, high byte first, and acknowledges each. High-byte bits above the array's address width are ignored.
- R5: Each data byte after the word address is acknowledged and presented for one cycle on wr_valid_o, wr_addr_o and wr_data_o. After each byte the pointer's low log2(PAGE) bits increment and wrap within the page, and the upper bits stay fixed.
- R6: A Stop that follows at least one written data byte raises commit_o for one cycle.
- R7: A read with no word-address phase returns the byte at the location after the last byte written or read.
- R8: A write-mode address phase, then a repeated Start and a read-mode device-select byte, returns the byte at the new word address first.
- R9: After each read byte, a host acknowledge makes the engine send the next location. A host no-acknowledge leaves SDA released.
- R10: Sequential reads increment the pointer over the whole array, wrapping from DEPTH-1 to 0.
- R11: SDA is only pulled low in the cycle after a falling SCL has been seen on the synchronized inputs, and it holds steady while SCL is high.
- R12: After reset SDA is released, no write is presented and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| strap_i | input | 3 | Device-select strap bits |
| sda_pull_o | output | 1 | 1 pulls the open-drain data line low |
| rd_addr_o | output | AW | Read-port address, the current pointer |
| rd_data_i | input | 8 | Read-port data for rd_addr_o, combinational |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | AW | Address of the received data byte |
| wr_data_o | output | 8 | Received data byte |
| commit_o | output | 1 | One-cycle pulse at Stop after written data |
| busy_i | input | 1 | Write buffer is busy with an internal cycle |

## Verification
The hardest case to reach from the ports is a Start that arrives partway through a byte. The pointer must survive it untouched, and device-select reception must restart cleanly. The bench drives four bits of a write address and then forces a Start. It then reads from the current address and compares the result with the location that earlier reads left the pointer at. Page wraparound is reached by writing seventy bytes from offset 60, so that the data overwrites the start of the page. Busy refusal is reached by polling straight after the commit pulse, while the bench's write-buffer model still holds busy high.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDATA,
        ST_RDATA
    } eep_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic dev_match(input logic [7:0] b, input logic [2:0] strap);
        return b[7:1] == {DEV_PREFIX, strap};
    endfunction

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/eep_cond_detect.sv
module eep_cond_detect
    import eep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [1:0] raw;
    logic [1:0] synced;
    logic       scl_q, sda_q;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw[g]),
            .dout(synced[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= synced[1];
            sda_q <= synced[0];
        end
    end

    always_comb begin
        ev.start = synced[1] & scl_q & sda_q & ~synced[0];
        ev.stop  = synced[1] & scl_q & ~sda_q & synced[0];
        ev.rise  = synced[1] & ~scl_q;
        ev.fall  = ~synced[1] & scl_q;
        ev.sda   = synced[0];
    end
endmodule

// File: rtl/eep_word_ptr.sv
module eep_word_ptr #(
    parameter int AW = 15,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          page_inc,
    input  logic          seq_inc,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] page_next;

    if (PW < AW) begin : g_split
        assign page_next = {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
    end else begin : g_flat
        assign page_next = ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)           ptr <= '0;
        else if (load)     ptr <= load_val;
        else if (page_inc) ptr <= page_next;
        else if (seq_inc)  ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/eep_slave_engine.sv
module eep_slave_engine
    import eep_pkg::*;
#(
    parameter  int DEPTH       = 32768,
    parameter  int PAGE        = 64,
    parameter  int SYNC_STAGES = 2,
    localparam int AW          = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic [2:0]    strap_i,
    output logic          sda_pull_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic [7:0]    rd_data_i,
    output logic          wr_valid_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [7:0]    wr_data_o,
    output logic          commit_o,
    input  logic          busy_i
);
    localparam int PW = $clog2(PAGE);
    localparam int HW = AW - 8;

    bus_ev_t       ev;
    eep_state_t    state;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg;
    logic [HW-1:0] addr_hi;
    logic          rw, mack, wr_pend, pull;
    logic [AW-1:0] ptr;
    logic          byte_end, slot_end;
    logic          ptr_load, ptr_page_inc, ptr_seq_inc;
    logic [2:0]    tx_idx;

    eep_cond_detect #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk  (clk),
        .rst  (rst),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .ev   (ev)
    );

    assign byte_end     = ev.fall && (bitcnt == 4'd8) && (state != ST_IDLE);
    assign slot_end     = ev.fall && (bitcnt == 4'd9) && (state != ST_IDLE);
    assign ptr_load     = byte_end && (state == ST_ALO);
    assign ptr_page_inc = byte_end && (state == ST_WDATA);
    assign ptr_seq_inc  = byte_end && (state == ST_RDATA);
    assign tx_idx       = 3'(4'd7 - bitcnt);

    eep_word_ptr #(.AW(AW), .PW(PW)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .load    (ptr_load),
        .load_val({addr_hi, shreg}),
        .page_inc(ptr_page_inc),
        .seq_inc (ptr_seq_inc),
        .ptr     (ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            addr_hi <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            wr_pend <= 1'b0;
            pull    <= 1'b0;
        end else if (ev.start) begin
            state  <= ST_DEV;
            bitcnt <= '0;
            pull   <= 1'b0;
        end else if (ev.stop) begin
            state   <= ST_IDLE;
            pull    <= 1'b0;
            wr_pend <= 1'b0;
        end else if (state != ST_IDLE) begin
            if (ev.rise) begin
                if (bitcnt < 4'd8 && state != ST_RDATA)
                    shreg <= {shreg[6:0], ev.sda};
                if (bitcnt == 4'd8 && state == ST_RDATA)
                    mack <= ~ev.sda;
                if (bitcnt < 4'd9)
                    bitcnt <= bitcnt + 4'd1;
            end else if (ev.fall) begin
                if (state == ST_RDATA && bitcnt != 4'd0 && bitcnt < 4'd8) begin
                    pull <= ~shreg[tx_idx];
                end else if (bitcnt == 4'd8) begin
                    unique case (state)
                        ST_DEV: begin
                            if (dev_match(shreg, strap_i) && !busy_i) begin
                                pull <= 1'b1;
                                rw   <= shreg[0];
                            end else begin
                                state <= ST_IDLE;
                                pull  <= 1'b0;
                            end
                        end
                        ST_AHI: begin
                            addr_hi <= shreg[HW-1:0];
                            pull    <= 1'b1;
                        end
                        ST_ALO:   pull <= 1'b1;
                        ST_WDATA: begin
                            pull    <= 1'b1;
                            wr_pend <= 1'b1;
                        end
                        default:  pull <= 1'b0;
                    endcase
                end else if (bitcnt == 4'd9) begin
                    bitcnt <= '0;
                    unique case (state)
                        ST_DEV: begin
                            if (rw) begin
                                state <= ST_RDATA;
                                shreg <= rd_data_i;
                                pull  <= ~rd_data_i[7];
                            end else begin
                                state <= ST_AHI;
                                pull  <= 1'b0;
                            end
                        end
                        ST_AHI: begin
                            state <= ST_ALO;
                            pull  <= 1'b0;
                        end
                        ST_ALO: begin
                            state <= ST_WDATA;
                            pull  <= 1'b0;
                        end
                        ST_RDATA: begin
                            if (mack) begin
                                shreg <= rd_data_i;
                                pull  <= ~rd_data_i[7];
                            end else begin
                                state <= ST_IDLE;
                                pull  <= 1'b0;
                            end
                        end
                        default: pull <= 1'b0;
                    endcase
                end
            end
        end
    end

    assign sda_pull_o = pull;
    assign rd_addr_o  = ptr;
    assign wr_valid_o = ptr_page_inc;
    assign wr_addr_o  = ptr;
    assign wr_data_o  = shreg;
    assign commit_o   = ev.stop && wr_pend;

    logic unused_slot;
    assign unused_slot = slot_end;
endmodule

// File: rtl/eep_slave_checker.sv
module eep_slave_checker
    import eep_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ev_start,
    input logic       ev_stop,
    input logic       ev_fall,
    input eep_state_t st,
    input logic [3:0] bitcnt,
    input logic       pull,
    input logic       wr_valid,
    input logic       busy
);
    AST_START_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> !pull); // R1

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> !pull); // R1

    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DEV && bitcnt == 4'd8 && ev_fall && busy) |=> !pull); // R3

    AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> pull); // R5

    AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(pull) |-> $past(ev_fall)); // R11
endmodule

bind eep_slave_engine eep_slave_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .ev_start(ev.start),
    .ev_stop (ev.stop),
    .ev_fall (ev.fall),
    .st      (state),
    .bitcnt  (bitcnt),
    .pull    (sda_pull_o),
    .wr_valid(wr_valid_o),
    .busy    (busy_i)
);

// File: tb/test_eep_slave_engine.sv
module test_eep_slave_engine;
    localparam int DEPTH = 512;
    localparam int AW    = 9;
    localparam int PAGE  = 64;
    localparam int Q     = 8;
    localparam int BUSY  = 2000;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0, rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_pull, wr_valid, commit, busy;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;
    logic [7:0] model [DEPTH];
    wire sda_bus = sda_m & ~sda_pull;
    int errors = 0, checks = 0, commit_cnt = 0, busy_cnt = 0;
    int last_wr_addr = -1;

    always #10 clk = ~clk;

    assign rd_data = model[rd_addr];
    assign busy = busy_cnt != 0;

    eep_slave_engine #(.DEPTH(DEPTH), .PAGE(PAGE)) i_eep_slave_engine (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(STRAP),
        .sda_pull_o(sda_pull), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .commit_o(commit), .busy_i(busy)
    );

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] page_val(input int i);
        return 8'((i * 5 + 51) & 255);
    endfunction

    initial begin
        for (int a = 0; a < DEPTH; a++) model[a] = init_val(a);
    end

    always @(posedge clk) begin
        if (wr_valid) begin
            model[wr_addr] <= wr_data;
            last_wr_addr <= int'(wr_addr);
        end
        if (commit) begin
            commit_cnt <= commit_cnt + 1;
            busy_cnt <= BUSY;
        end else if (busy_cnt > 0) begin
            busy_cnt <= busy_cnt - 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0;
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1;
        repeat (Q / 2) @(negedge clk);
        ack = ~sda_bus;
        repeat (Q / 2) @(negedge clk);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit ackm, output logic [7:0] b, output bit stable);
        logic s1, s2;
        stable = 1'b1;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1;
            repeat (2) @(negedge clk);
            s1 = sda_bus;
            repeat (Q - 3) @(negedge clk);
            s2 = sda_bus;
            @(negedge clk);
            b[i] = s1;
            if (s1 != s2) stable = 1'b0;
            scl_m = 1'b0;
        end
        sda_m = ~ackm; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0;
        sda_m = 1'b1;
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
        bit ack;
        bus_start();
        send_byte(DEV_W, ack); chk(ack, req, ack, 1);
        send_byte(hi, ack);    chk(ack, req, ack, 1);
        send_byte(lo, ack);    chk(ack, req, ack, 1);
    endtask

    task automatic read_run(input int n, input int first, input bit use_model,
                            input string req);
        bit ack, st;
        logic [7:0] b;
        int a, e;
        bus_start();
        send_byte(DEV_R, ack); chk(ack, req, ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b, st);
            a = (first + i) % DEPTH;
            e = use_model ? int'(model[a]) : int'(init_val(a));
            chk(b == 8'(e), req, b, e);
            if (i == 0) chk(st, "R11", st, 1);
        end
    endtask

    initial begin
        bit ack, st;
        logic [7:0] b;
        int pre_commit, exp_v, i0;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(sda_pull == 1'b0, "R12", sda_pull, 0);
        chk(wr_valid == 1'b0, "R12", wr_valid, 0);

        // R12: pointer starts at 0, read without word address
        read_run(1, 0, 1'b0, "R12");
        bus_stop();

        // R2: strap sweep
        for (int s = 0; s < 8; s++) begin
            bus_start();
            send_byte({4'b1010, 3'(s), 1'b0}, ack);
            chk(ack == (3'(s) == STRAP), "R2", ack, int'(3'(s) == STRAP));
            if (3'(s) != STRAP) begin
                send_byte(8'h00, ack);
                chk(!ack, "R2", ack, 0);
            end
            bus_stop();
        end
        bus_start();
        send_byte({4'b1011, STRAP, 1'b0}, ack);
        chk(!ack, "R2", ack, 0);
        bus_stop();

        // R4 R8: random reads, including an ignored high bit
        set_addr(8'h00, 8'd5, "R4");   read_run(1, 5, 1'b0, "R8");   bus_stop();
        set_addr(8'h01, 8'd44, "R4");  read_run(2, 300, 1'b0, "R8"); bus_stop();
        set_addr(8'h01, 8'hFF, "R4");  read_run(1, 511, 1'b0, "R8"); bus_stop();
        set_addr(8'h81, 8'h23, "R4");  read_run(1, 291, 1'b0, "R4"); bus_stop();

        // R5: page write of 70 bytes from offset 60 of page 2
        pre_commit = commit_cnt;
        set_addr(8'h00, 8'd188, "R5");
        for (int i = 0; i < 70; i++) begin
            send_byte(page_val(i), ack);
            chk(ack, "R5", ack, 1);
            chk(last_wr_addr == 128 + ((60 + i) % 64), "R5", last_wr_addr,
                128 + ((60 + i) % 64));
        end
        bus_stop();
        chk(commit_cnt == pre_commit + 1, "R6", commit_cnt, pre_commit + 1);

        // R3: polling while busy, then after busy ends
        bus_start();
        send_byte(DEV_W, ack);
        chk(!ack, "R3", ack, 0);
        bus_stop();
        repeat (BUSY + 50) @(negedge clk);
        bus_start();
        send_byte(DEV_W, ack);
        chk(ack, "R3", ack, 1);
        bus_stop();
        chk(commit_cnt == pre_commit + 1, "R6", commit_cnt, pre_commit + 1);

        // R7: current address after page write is 130
        bus_start();
        send_byte(DEV_R, ack); chk(ack, "R7", ack, 1);
        recv_byte(1'b0, b, st);
        chk(b == page_val(6), "R7", b, page_val(6));
        bus_stop();

        // R9 R5: sequential read of the whole page, arithmetic expectations
        set_addr(8'h00, 8'd128, "R9");
        bus_start();
        send_byte(DEV_R, ack); chk(ack, "R9", ack, 1);
        for (int o = 0; o < 64; o++) begin
            recv_byte(o != 63, b, st);
            i0 = (o + 4) % 64;
            if (i0 + 64 < 70) i0 = i0 + 64;
            exp_v = int'(page_val(i0));
            chk(b == 8'(exp_v), "R9", b, exp_v);
        end
        bus_stop();
        set_addr(8'h00, 8'd127, "R5"); read_run(1, 127, 1'b0, "R5"); bus_stop();
        set_addr(8'h00, 8'd192, "R5"); read_run(1, 192, 1'b0, "R5"); bus_stop();

        // R10: wrap from the top location, NACK leaves SDA released
        set_addr(8'h01, 8'd252, "R10");
        read_run(8, 508, 1'b0, "R10");
        repeat (4) @(negedge clk);
        chk(sda_pull == 1'b0, "R9", sda_pull, 0);
        bus_stop();

        // R7: pointer continues at 4
        read_run(1, 4, 1'b0, "R7");
        bus_stop();

        // R1: Start in the middle of an address byte aborts, pointer kept at 5
        bus_start();
        send_byte(DEV_W, ack); chk(ack, "R1", ack, 1);
        for (int i = 0; i < 4; i++) begin
            sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0;
        end
        read_run(1, 5, 1'b0, "R1");
        bus_stop();
        chk(sda_pull == 1'b0, "R1", sda_pull, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule